// File: doc/BRIEF.md
# Addressable Latch with Decoder Mode

This block stores eight single-bit values and updates one of them at a time. A 3-bit address picks the target bit. One data input supplies the value. An active-low enable and an active-low clear together pick one of four behaviours:

- **Write:** the addressed bit takes the data value.
- **Hold:** every bit keeps its value.
- **Clear:** every bit is forced to zero.
- **Decode:** the addressed bit takes the data value and every other bit is forced to zero. The output then acts as a one-hot decoder, gated by the data bit.

The block is clocked so that it can be synthesized. On each rising clock edge it evaluates the level rules, so every input change appears on the outputs one cycle later. A synchronous active-high reset zeroes all eight bits and overrides every mode. Callers should keep the address steady while enable is low. If the address moves during a write, each address present at a clock edge is written.

Top module: `addr_latch_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, all eight bits of `latchQ` are 0 after that edge. This holds whatever the other inputs are.
- R2: Address value k, with `addr[2]` as the most significant bit, selects bit k of `latchQ`. So 3'b000 selects bit 0 and 3'b111 selects bit 7. With `enN`=0 and `clrN`=1, the selected bit equals `dIn` after the edge.
- R3: In write mode (`enN`=0, `clrN`=1), the seven unselected bits keep their previous values.
- R4: With `enN`=1 and `clrN`=1, all bits keep their values whatever `dIn` and `addr` do. This includes the first edge after write or decode mode ends, so the last written value is retained.
- R5: With `enN`=1 and `clrN`=0, all eight bits are 0 after the edge.
- R6: With `enN`=0 and `clrN`=0, the selected bit equals `dIn` and every other bit is 0 after the edge.
- R7: An input change does not alter `latchQ` until the next rising edge, and it is visible right after that edge.
- R8: If `addr` changes while `enN` stays 0 in write mode, each address present at an edge is written with the `dIn` of that edge. Earlier addresses keep the values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dIn | input | 1 | Data bit to store |
| addr | input | 3 | Latch select, bit 2 most significant |
| enN | input | 1 | Enable, active low |
| clrN | input | 1 | Clear, active low |
| latchQ | output | 8 | Stored latch bits |

## Verification
A wrong mode decode or a wrong address decode shows on `latchQ` just after the very next edge. Examples are a wrong bit written, a neighbour disturbed, or a clear that fails to act. So the reference comparison after every edge localizes a fault to one cycle. A state fault that only the hold mode would hide is forced out by following each hold with a different mode. Decode steps zero every bit except the addressed one, so earlier corruption cannot hide there.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_CLEAR  = 2'd2,
    MODE_DECODE = 2'd3
  } latch_mode_e;

  typedef struct packed {
    logic loadSel;     // selected bit takes dataBit
    logic zeroOthers;  // unselected bits forced low
    logic zeroAll;     // every bit forced low
    logic dataBit;
  } latch_strobe_t;

endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_LATCH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enN,
  input  logic              clrN,
  output latch_strobe_t     strobe,
  output logic [NUM_LATCH-1:0] selOneHot
);

  latch_mode_e mode;

  always_comb begin
    unique case ({enN, clrN})
      2'b01:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b10:   mode = MODE_CLEAR;
      default: mode = MODE_DECODE;
    endcase
  end

  always_comb begin
    strobe            = '0;
    strobe.dataBit    = dIn;
    strobe.loadSel    = (mode == MODE_WRITE) || (mode == MODE_DECODE);
    strobe.zeroOthers = (mode == MODE_DECODE);
    strobe.zeroAll    = (mode == MODE_CLEAR);
  end

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_sel
    assign selOneHot[i] = (addr == ADDR_W'(i));
  end

  // R2: exactly one latch selected at any time
  a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
    $countones(selOneHot) == 1);

  // R5/R6: a clear strobe never coexists with loading
  a_r5_clear_excl: assert property (@(posedge clk) disable iff (rst)
    strobe.zeroAll |-> !strobe.loadSel && !strobe.zeroOthers);

endmodule

// File: rtl/addr_latch_store.sv
module addr_latch_store
  import addr_latch_pkg::*;
#(
  parameter int NUM_LATCH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  latch_strobe_t        strobe,
  input  logic [NUM_LATCH-1:0] selOneHot,
  output logic [NUM_LATCH-1:0] bits
);

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                bits[i] <= 1'b0;
      else if (strobe.zeroAll)                bits[i] <= 1'b0;
      else if (strobe.loadSel && selOneHot[i]) bits[i] <= strobe.dataBit;
      else if (strobe.zeroOthers)             bits[i] <= 1'b0;
    end
  end

  // R1: reset empties storage
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> bits == '0);

  // R3: bits not selected by a plain write keep their value
  a_r3_others_kept: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadSel && !strobe.zeroOthers) |=>
      ((bits & ~$past(selOneHot)) == ($past(bits) & ~$past(selOneHot))));

endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_LATCH = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dIn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 enN,
  input  logic                 clrN,
  output logic [NUM_LATCH-1:0] latchQ
);

  latch_strobe_t        strobe;
  logic [NUM_LATCH-1:0] selOneHot;

  addr_latch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .dIn(dIn), .addr(addr), .enN(enN), .clrN(clrN),
    .strobe(strobe), .selOneHot(selOneHot)
  );

  addr_latch_store #(.NUM_LATCH(NUM_LATCH)) u_store (
    .clk(clk), .rst(rst), .strobe(strobe), .selOneHot(selOneHot),
    .bits(latchQ)
  );

  // R2: addressed bit takes the data in write mode
  a_r2_write_bit: assert property (@(posedge clk) disable iff (rst)
    (!enN && clrN) |=> latchQ[$past(addr)] == $past(dIn));

  // R4: hold mode freezes everything
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (enN && clrN) |=> $stable(latchQ));

  // R5: clear mode empties all bits
  a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
    (enN && !clrN) |=> latchQ == '0);

  // R6: decode mode gives data-gated one-hot
  a_r6_decode: assert property (@(posedge clk) disable iff (rst)
    (!enN && !clrN) |=>
      latchQ == ({{(NUM_LATCH-1){1'b0}}, $past(dIn)} << $past(addr)));

endmodule

// File: tb/addr_latch_decoder_test.sv
module addr_latch_decoder_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dIn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       enN = 1'b1;
  logic       clrN = 1'b1;
  logic [7:0] latchQ;

  logic [7:0] model = 8'h00;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  addr_latch_decoder uut (
    .clk(clk), .rst(rst), .dIn(dIn), .addr(addr), .enN(enN), .clrN(clrN),
    .latchQ(latchQ)
  );

  function automatic logic [7:0] refNext(input logic [7:0] cur);
    logic [7:0] n;
    n = cur;
    if (rst) n = 8'h00;
    else if (enN && !clrN) n = 8'h00;
    else if (!enN && clrN) n[addr] = dIn;
    else if (!enN && !clrN) begin n = 8'h00; n[addr] = dIn; end
    return n;
  endfunction

  task automatic compare(input string tag, input logic [7:0] expv);
    checks++;
    if (latchQ !== expv) begin
      fails++;
      $display("FAIL %s: latchQ=%h expected=%h", tag, latchQ, expv);
    end
  endtask

  // one edge: model advances with current inputs, result sampled after edge
  task automatic step(input string tag);
    model = refNext(model);
    @(posedge clk);
    #1;
    compare(tag, model);
  endtask

  task automatic doReset();
    rst = 1'b1; dIn = 1'b1; enN = 1'b0; clrN = 1'b1; addr = 3'd5;
    step("R1 reset");
    step("R1 reset held");
    rst = 1'b0; enN = 1'b1;
  endtask

  task automatic testWrite();
    for (int k = 0; k < 8; k++) begin
      enN = 1'b1; addr = 3'(k); dIn = (k % 3) != 1;
      step("R4 addr setup hold");
      enN = 1'b0;
      #1 compare("R7 no change before edge", model);
      step($sformatf("R2 R3 write addr %0d", k));
    end
    enN = 1'b1;
    step("R4 retain after enable high");
  endtask

  task automatic testHold();
    for (int k = 0; k < 8; k++) begin
      enN = 1'b1; clrN = 1'b1; addr = 3'(7 - k); dIn = k[0];
      step($sformatf("R4 hold addr %0d", 7 - k));
    end
  endtask

  task automatic testClear();
    for (int k = 0; k < 8; k++) begin
      enN = 1'b0; clrN = 1'b1; addr = 3'(k); dIn = 1'b1;
      step("R2 fill");
    end
    enN = 1'b1; clrN = 1'b0;
    step("R5 clear all");
    clrN = 1'b1;
    step("R4 hold after clear");
  endtask

  task automatic testDecode();
    for (int k = 0; k < 8; k++) begin
      enN = 1'b0; clrN = 1'b0; addr = 3'(k); dIn = 1'b1;
      step($sformatf("R6 decode one addr %0d", k));
      dIn = 1'b0;
      step($sformatf("R6 decode zero addr %0d", k));
    end
  endtask

  task automatic testDecodeToHold();
    for (int k = 0; k < 8; k++) begin
      enN = 1'b0; clrN = 1'b0; addr = 3'(k); dIn = 1'b1;
      step("R6 decode before hold");
      enN = 1'b1; clrN = 1'b1; addr = 3'(k ^ 3'd5); dIn = 1'b0;
      step($sformatf("R4 decode to hold addr %0d", k));
      step("R4 hold persists");
    end
  endtask

  task automatic testAddrSlew();
    enN = 1'b1; clrN = 1'b0;
    step("R5 clear before slew");
    clrN = 1'b1; enN = 1'b0; dIn = 1'b1; addr = 3'd2;
    step("R8 slew first");
    addr = 3'd6;
    step("R8 slew second");
    addr = 3'd3; dIn = 1'b0;
    step("R8 slew third");
    enN = 1'b1;
    step("R8 slew result held");
    compare("R8 both written", 8'b0100_0100);
  endtask

  initial begin
    #1;
    doReset();
    testWrite();
    testHold();
    testClear();
    testDecode();
    testDecodeToHold();
    testAddrSlew();
    rst = 1'b1;
    step("R1 reset overrides");
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: latchQ=%h expected=done", latchQ);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule